// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave port. A host uses it to reach three registers inside the block. Reads return either the latest conversion result, which is 24 bits wide, or a 16-bit status word. Writes load a 16-bit configuration word, and the block presents that word in parallel to the logic around it. The host interface has these pins: an active-low select, a read/write direction pin, a register select pin, a serial clock, serial data in, and serial data out with an output enable. The block runs on a system clock that is faster than the serial clock, and it detects the serial clock edges by sampling.

On the core side, a load strobe captures a new conversion word into a holding register and raises the data-ready flag. When a frame begins, the port copies the register chosen for reading into its output shift register. This means a result that arrives during a read cannot corrupt the word that is leaving the port. A completed read of the conversion register lowers data-ready, unless a newer result arrived while that read was in progress.

Top module: `serreg_port`

## Requirements
- R1: Read data leaves the port most significant bit first. The first bit is on `sdo` as soon as the frame starts, and each later bit appears after a rising `sclk` edge. `sdo` never changes on a falling `sclk` edge.
- R2: `sdo_oe` is 1 only while `cs_n` is 0 and `rw` is 1. It is 0 whenever `cs_n` is 1 or `rw` is 0.
- R3: When a read frame starts with `rsel` = 1, the frame returns the 24-bit conversion word most recently captured by `conv_load`.
- R4: When a read frame starts with `rsel` = 0, the frame returns the 16-bit `status_word` as it stood when the frame started.
- R5: In a write frame (`rw` = 0), `sdi` is sampled on each falling `sclk` edge, most significant bit first. After the 16th falling edge, `cfg_word` takes the 16 sampled bits.
- R6: `drdy` rises on the cycle after `conv_load`. A fully completed 24-bit read of the conversion register lowers it. An aborted read or a status read leaves it high.
- R7: A write frame that `cs_n` ends before the 16th falling edge leaves `cfg_word` unchanged.
- R8: A `conv_load` during a conversion read does not change the word being shifted out. It also keeps `drdy` at 1 after that read completes.
- R9: `sclk` edges beyond the frame length are ignored until `cs_n` goes high. After reset, `cfg_word` equals the parameter `CFG_RESET` and `drdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low port select |
| rw | input | 1 | 1 = read, 0 = write |
| rsel | input | 1 | 1 = conversion register, 0 = status register |
| sclk | input | 1 | Serial clock (slower than clk) |
| sdi | input | 1 | Serial write data |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for sdo |
| drdy | output | 1 | New conversion result available |
| conv_data | input | CONV_W | Parallel conversion word |
| conv_load | input | 1 | Capture strobe for conv_data |
| status_word | input | REG_W | Parallel status word |
| cfg_word | output | REG_W | Configuration register contents |

## Verification
A wrong bit counter shows up at the end of a frame, at the latest. The configuration word would update one edge early or late, or would update on an aborted write. The read word would also come out shifted by one place. A lost or stale data-ready bit shows up directly on `drdy` within one system cycle of the load or of the final falling edge. A capture that happens at the wrong time shows up only as corrupted bits after a mid-read load, so the bench makes that load part way through a frame.

// File: rtl/serreg_port.sv
module serreg_port #(
  parameter int CONV_W = 24,
  parameter int REG_W = 16,
  parameter logic [REG_W-1:0] CFG_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              rsel,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              drdy,
  input  logic [CONV_W-1:0] conv_data,
  input  logic              conv_load,
  input  logic [REG_W-1:0]  status_word,
  output logic [REG_W-1:0]  cfg_word
);
  localparam int CNT_W = $clog2(CONV_W + 1);
  localparam int PAD_W = CONV_W - REG_W;

  logic sclk_q, cs_q, rd_q, sel_q, late;
  logic [CNT_W-1:0] cnt;
  logic [CONV_W-1:0] conv_q, out_sr;
  logic [REG_W-1:0] in_sr;

  wire rise  = sclk & ~sclk_q;
  wire fall  = ~sclk & sclk_q;
  wire start = ~cs_n & cs_q;
  wire [CNT_W-1:0] flen = (rd_q && sel_q) ? CNT_W'(CONV_W) : CNT_W'(REG_W);
  wire run   = ~cs_n & ~start & (cnt != flen);
  wire wr_done = run & fall & ~rd_q & (cnt == CNT_W'(REG_W - 1));
  wire rd_done = run & fall & rd_q & sel_q & (cnt == CNT_W'(CONV_W - 1));

  assign sdo_oe = ~cs_n & rw;
  assign sdo    = out_sr[CONV_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; cs_q <= 1'b1; rd_q <= 1'b0; sel_q <= 1'b0; late <= 1'b0;
      cnt <= '0; conv_q <= '0; out_sr <= '0; in_sr <= '0;
      cfg_word <= CFG_RESET; drdy <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (conv_load) conv_q <= conv_data;

      if (cs_n) begin
        cnt <= '0;
      end else if (start) begin
        cnt   <= '0;
        rd_q  <= rw;
        sel_q <= rsel;
        late  <= 1'b0;
        out_sr <= rsel ? conv_q : {status_word, {PAD_W{1'b0}}};
      end else if (run) begin
        if (conv_load) late <= 1'b1;
        if (fall) begin
          cnt <= cnt + 1'b1;
          if (!rd_q) in_sr <= {in_sr[REG_W-2:0], sdi};
        end
        if (rise && cnt != '0) out_sr <= out_sr << 1;
      end

      if (wr_done) cfg_word <= {in_sr[REG_W-2:0], sdi};

      if (conv_load) drdy <= 1'b1;
      else if (rd_done) drdy <= late;
    end
  end
endmodule

module serreg_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rw,
  input logic sclk_q,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe,
  input logic drdy,
  input logic conv_load,
  input logic rd_q,
  input logic sel_q,
  input logic [15:0] cfg_word
);
  AST_OE_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !rw) |-> !sdo_oe); // R2
  AST_SDO_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk_q && !sclk) |=> $stable(sdo)); // R1
  AST_DRDY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_load |=> drdy); // R6
  AST_DRDY_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy) |-> $past(!cs_n && rd_q && sel_q)); // R6
  AST_CFG_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> $past(!cs_n && !rd_q)); // R5
endmodule

bind serreg_port serreg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .sclk_q(sclk_q), .sclk(sclk),
  .sdo(sdo), .sdo_oe(sdo_oe), .drdy(drdy), .conv_load(conv_load),
  .rd_q(rd_q), .sel_q(sel_q), .cfg_word(cfg_word)
);

// File: tb/serreg_port_bench.sv
module serreg_port_bench;
  localparam logic [15:0] CFG_RST = 16'hA5C3;
  logic clk = 0, rst_n = 0, cs_n = 1, rw = 1, rsel = 1, sclk = 0, sdi = 0;
  logic conv_load = 0;
  logic [23:0] conv_data = '0;
  logic [15:0] status_word = '0;
  logic sdo, sdo_oe, drdy;
  logic [15:0] cfg_word;
  int tests = 0, fails = 0;

  serreg_port #(.CFG_RESET(CFG_RST)) u_serreg_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .rsel(rsel), .sclk(sclk),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .drdy(drdy), .conv_data(conv_data),
    .conv_load(conv_load), .status_word(status_word), .cfg_word(cfg_word));

  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] v);
    conv_data = v; conv_load = 1; tick(1); conv_load = 0; tick(1);
  endtask

  task automatic rd(input logic sel, input int nbits, input int midload,
                    input logic [23:0] midval, output logic [23:0] got);
    got = '0;
    cs_n = 0; rw = 1; rsel = sel; tick(2);
    check("R2 oe in read", 32'(sdo_oe), 32'd1);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1; tick(2);
      got = {got[22:0], sdo};
      if (i == midload) load(midval);
      sclk = 0; tick(2);
    end
    cs_n = 1; tick(2);
  endtask

  task automatic wr(input logic [15:0] v, input int nbits);
    cs_n = 0; rw = 0; tick(2);
    check("R2 oe in write", 32'(sdo_oe), 32'd0);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? v[15-i] : ~sdi;
      sclk = 1; tick(2);
      sclk = 0; tick(2);
    end
    cs_n = 1; rw = 1; tick(2);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] got, v;
    logic [15:0] c;
    tick(3); rst_n = 1; tick(2);
    check("R9 reset cfg", 32'(cfg_word), 32'(CFG_RST));
    check("R9 reset drdy", 32'(drdy), 32'd0);
    check("R2 idle oe", 32'(sdo_oe), 32'd0);

    for (int k = 0; k < 10; k++) begin
      v = 24'(k * 24'h1F3A5B + 24'h800001) ^ (24'h1 << k);
      load(v);
      check("R6 drdy after load", 32'(drdy), 32'd1);
      rd(1'b1, 24, -1, '0, got);
      check("R1 R3 conversion read", 32'(got), 32'(v));
      check("R6 drdy cleared by read", 32'(drdy), 32'd0);
    end

    for (int k = 0; k < 8; k++) begin
      load(24'h123456);
      status_word = 16'(k * 16'h2D1B + 16'h8001);
      rd(1'b0, 16, -1, '0, got);
      check("R4 status read", 32'(got[15:0]), 32'(status_word));
      check("R6 status read keeps drdy", 32'(drdy), 32'd1);
    end

    rd(1'b1, 9, -1, '0, got);
    check("R6 aborted read keeps drdy", 32'(drdy), 32'd1);

    load(24'hC0FFEE);
    rd(1'b1, 24, 9, 24'h5A5A5A, got);
    check("R8 midload keeps word", 32'(got), 32'hC0FFEE);
    check("R8 drdy survives", 32'(drdy), 32'd1);
    rd(1'b1, 24, -1, '0, got);
    check("R3 newer word read", 32'(got), 32'h5A5A5A);

    for (int k = 0; k < 8; k++) begin
      c = 16'(k * 16'h3B71 + 16'h0F0F) ^ (16'h1 << (2 * k));
      wr(c, 16);
      check("R5 write cfg", 32'(cfg_word), 32'(c));
      wr(~c, 15);
      check("R7 aborted write", 32'(cfg_word), 32'(c));
    end

    wr(16'h3C69, 21);
    check("R9 extra sclk ignored", 32'(cfg_word), 32'h3C69);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule